// File: doc/BRIEF.md
# Two-Source Byte Permute Unit

This unit assembles a 128-bit result vector out of byte lanes taken from two 128-bit source vectors. It serves as the byte crossbar behind vector permute operations. It has two modes, and a single mode bit picks between them for each accepted input.

In the fixed-index mode, a control word carries sixteen 5-bit indices, one for each result byte. Each index picks one byte out of the 32 bytes of both sources taken together. In the data-driven mode, each result byte takes its index from the matching byte of the second source vector. That index can only reach the first source, and any index byte that is out of range produces a zero byte.

The byte selection is combinational and the result is registered. A result and its valid flag appear one clock after the input strobe. The result then holds until the next accepted input.

Top module: `vec_byte_permute`

## Requirements
- R1: Byte lane n of every vector port (`src_a`, `src_b`, `perm_data`) occupies bits 8n+7 down to 8n, with bit 0 the least significant bit. Index field n of `sel_ctrl` occupies bits 5n+4 down to 5n.
- R2: When `mode_swz` is 0 (fixed-index mode), an index value k from 0 to 15 in field n makes result byte n equal to byte k of `src_a`.
- R3: In fixed-index mode, an index value k from 16 to 31 in field n makes result byte n equal to byte k-16 of `src_b`.
- R4: When `mode_swz` is 1 (data-driven mode), byte n of `src_b` is the index for result byte n. A value k from 0 to 15 makes result byte n equal to byte k of `src_a`.
- R5: In data-driven mode, an index byte whose full 8-bit value is 16 or more gives a zero result byte. The upper index bits are not masked, so for example 0x10, 0x80 and 0xFF all give zero.
- R6: In data-driven mode, `sel_ctrl` has no effect on the result.
- R7: `perm_valid` is 1 in exactly the cycle after a cycle where `in_valid` was 1 at the clock edge, and 0 otherwise. `perm_data` carries the result for the input accepted at that edge.
- R8: A synchronous active-high `rst` clears `perm_valid` and `perm_data` to 0.
- R9: While `in_valid` is 0, `perm_data` keeps its last value, whatever the other inputs do.
- R10: A fixed-index request in which field n holds n for every lane returns `src_a` unchanged. A request in which all sixteen fields hold the same i below 16 returns byte i of `src_a` in every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept strobe for the current inputs |
| mode_swz | input | 1 | 0 = fixed-index mode, 1 = data-driven mode |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector; holds the per-lane indices in data-driven mode |
| sel_ctrl | input | 80 | Sixteen 5-bit fixed-mode indices |
| perm_valid | output | 1 | Result valid flag, registered |
| perm_data | output | 128 | Permuted result, registered |

## Verification
Every result is due exactly one rising edge after the edge at which `in_valid` was seen high. The bench drives its inputs on the falling edge and samples `perm_data` and `perm_valid` one nanosecond after the next rising edge, so each comparison falls inside that single-cycle window. For the hold and no-effect cases, the bench changes the inputs with `in_valid` low, lets one or more edges pass, and confirms that the registered result has not moved. The reset value is sampled after the first edge with `rst` high.

// File: rtl/byteperm_pkg.sv
package byteperm_pkg;

    // Geometry of the vector and its index fields
    localparam int LANES   = 16;
    localparam int LANE_W  = 8;
    localparam int VEC_W   = LANES * LANE_W;
    localparam int IDX_W   = $clog2(2 * LANES);
    localparam int SEL_W   = $clog2(LANES);
    localparam int CTRL_W  = LANES * IDX_W;

    // Data-driven indices at or above this value select nothing
    localparam logic [LANE_W-1:0] LANE_LIMIT = LANE_W'(LANES);

    typedef enum logic {
        MODE_FIXED = 1'b0,
        MODE_DATA  = 1'b1
    } perm_mode_e;

    // Decoded routing for one result byte
    typedef struct packed {
        logic             zero;
        logic             from_b;
        logic [SEL_W-1:0] byte_idx;
    } lane_sel_t;

    typedef logic [LANE_W-1:0] lane_t;

    // Pick byte k out of a vector
    function automatic lane_t get_lane(input logic [VEC_W-1:0] v, input logic [SEL_W-1:0] k);
        return v[int'(k) * LANE_W +: LANE_W];
    endfunction

endpackage

// File: rtl/byteperm_index_gen.sv
module byteperm_index_gen
    import byteperm_pkg::*;
(
    input  perm_mode_e           mode,
    input  logic [IDX_W-1:0]     fixed_idx,
    input  logic [LANE_W-1:0]    data_idx,
    output lane_sel_t            sel
);

    always_comb begin
        sel = '0;
        case (mode)
            MODE_FIXED: begin
                sel.zero     = 1'b0;
                sel.from_b   = fixed_idx[IDX_W-1];
                sel.byte_idx = fixed_idx[SEL_W-1:0];
            end
            MODE_DATA: begin
                sel.zero     = (data_idx >= LANE_LIMIT);
                sel.from_b   = 1'b0;
                sel.byte_idx = data_idx[SEL_W-1:0];
            end
            default: sel = '0;
        endcase
    end

endmodule

// File: rtl/byteperm_lane_mux.sv
module byteperm_lane_mux
    import byteperm_pkg::*;
(
    input  logic [VEC_W-1:0] vec_a,
    input  logic [VEC_W-1:0] vec_b,
    input  lane_sel_t        sel,
    output lane_t            lane_out
);

    lane_t pick_a;
    lane_t pick_b;

    always_comb begin
        pick_a = get_lane(vec_a, sel.byte_idx);
        pick_b = get_lane(vec_b, sel.byte_idx);
        if (sel.zero)
            lane_out = '0;
        else if (sel.from_b)
            lane_out = pick_b;
        else
            lane_out = pick_a;
    end

endmodule

// File: rtl/byteperm_out_reg.sv
module byteperm_out_reg #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic         q_valid,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q       <= '0;
        end else begin
            q_valid <= load;
            if (load)
                q <= d;
        end
    end

endmodule

// File: rtl/vec_byte_permute.sv
module vec_byte_permute
    import byteperm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              mode_swz,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic [CTRL_W-1:0] sel_ctrl,
    output logic              perm_valid,
    output logic [VEC_W-1:0]  perm_data
);

    perm_mode_e       mode;
    logic [VEC_W-1:0] result;

    assign mode = perm_mode_e'(mode_swz);

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        lane_sel_t sel;
        lane_t     byte_out;

        byteperm_index_gen u_idx (
            .mode      (mode),
            .fixed_idx (sel_ctrl[n*IDX_W +: IDX_W]),
            .data_idx  (src_b[n*LANE_W +: LANE_W]),
            .sel       (sel)
        );

        byteperm_lane_mux u_mux (
            .vec_a    (src_a),
            .vec_b    (src_b),
            .sel      (sel),
            .lane_out (byte_out)
        );

        assign result[n*LANE_W +: LANE_W] = byte_out;
    end

    byteperm_out_reg #(.W(VEC_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .load    (in_valid),
        .d       (result),
        .q_valid (perm_valid),
        .q       (perm_data)
    );

endmodule

// File: rtl/vec_byte_permute_chk.sv
module vec_byte_permute_chk
    import byteperm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              mode_swz,
    input logic [VEC_W-1:0]  src_a,
    input logic [VEC_W-1:0]  src_b,
    input logic [CTRL_W-1:0] sel_ctrl,
    input logic              perm_valid,
    input logic [VEC_W-1:0]  perm_data
);

    // Expected byte 0 for a fixed-index request, from the port-level rule
    logic [IDX_W-1:0] k0;
    lane_t            want0;
    always_comb begin
        k0 = sel_ctrl[IDX_W-1:0];
        if (k0 < IDX_W'(LANES))
            want0 = src_a[int'(k0) * LANE_W +: LANE_W];
        else
            want0 = src_b[(int'(k0) - LANES) * LANE_W +: LANE_W];
    end

    // R7: an accepted input is followed by a valid result
    p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> perm_valid);

    // R7: no valid result without an accepted input
    p_no_stray_valid_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !perm_valid);

    // R9: result holds while idle
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(perm_data));

    // R8: reset clears the output
    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (!perm_valid && perm_data == '0));

    // R5: out-of-range data-driven index in lane 0 yields zero
    p_swz_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_swz && src_b[LANE_W-1:0] >= LANE_LIMIT) |=> perm_data[LANE_W-1:0] == '0);

    // R2 and R3: lane 0 of a fixed-index request follows its index
    p_fixed_lane0_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode_swz) |=> perm_data[LANE_W-1:0] == $past(want0));

endmodule

bind vec_byte_permute vec_byte_permute_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .mode_swz   (mode_swz),
    .src_a      (src_a),
    .src_b      (src_b),
    .sel_ctrl   (sel_ctrl),
    .perm_valid (perm_valid),
    .perm_data  (perm_data)
);

// File: tb/vec_byte_permute_tb.sv
module vec_byte_permute_tb;

    localparam int L  = 16;
    localparam int VW = 128;
    localparam int CW = 80;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          mode_swz = 1'b0;
    logic [VW-1:0] src_a = '0;
    logic [VW-1:0] src_b = '0;
    logic [CW-1:0] sel_ctrl = '0;
    logic          perm_valid;
    logic [VW-1:0] perm_data;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic [31:0] lfsr = 32'h1ACE_5EED;

    always #2 clk = ~clk;

    vec_byte_permute u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode_swz(mode_swz),
        .src_a(src_a), .src_b(src_b), .sel_ctrl(sel_ctrl),
        .perm_valid(perm_valid), .perm_data(perm_data)
    );

    function automatic logic [VW-1:0] model(input logic m, input logic [VW-1:0] a,
                                            input logic [VW-1:0] b, input logic [CW-1:0] c);
        logic [VW-1:0] r;
        for (int n = 0; n < L; n++) begin
            int k;
            if (!m) begin
                k = int'(c[5*n +: 5]);
                r[8*n +: 8] = (k < 16) ? a[8*k +: 8] : b[8*(k-16) +: 8];
            end else begin
                k = int'(b[8*n +: 8]);
                r[8*n +: 8] = (k < 16) ? a[8*k +: 8] : 8'h00;
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic check_vec(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Drive one request, then sample after the following rising edge
    task automatic run(input string req, input logic m, input logic [VW-1:0] a,
                       input logic [VW-1:0] b, input logic [CW-1:0] c);
        @(negedge clk);
        mode_swz = m; src_a = a; src_b = b; sel_ctrl = c; in_valid = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0;
        check_bit({req, " valid"}, perm_valid, 1'b1);
        check_vec(req, perm_data, model(m, a, b, c));
    endtask

    function automatic logic [VW-1:0] rand_vec();
        logic [VW-1:0] v;
        for (int w = 0; w < 4; w++) begin
            lfsr = step(lfsr);
            v[32*w +: 32] = lfsr ^ (lfsr << 7);
        end
        return v;
    endfunction

    initial begin
        logic [VW-1:0] pa, pb, held;
        logic [CW-1:0] c;
        for (int n = 0; n < L; n++) begin
            pa[8*n +: 8] = 8'h10 + 8'(n);
            pb[8*n +: 8] = 8'hC0 + 8'(n);
        end

        // R8: reset state
        repeat (2) @(posedge clk);
        #1;
        check_bit("R8 reset valid", perm_valid, 1'b0);
        check_vec("R8 reset data", perm_data, '0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        check_bit("R7 idle valid low", perm_valid, 1'b0);

        // R1 R2 R3 R10: every index value broadcast to all lanes
        for (int k = 0; k < 32; k++) begin
            for (int n = 0; n < L; n++) c[5*n +: 5] = 5'(k);
            run(k < 16 ? "R2 R10 broadcast" : "R3 broadcast", 1'b0, pa, pb, c);
        end

        // R10: identity fixed-index request
        for (int n = 0; n < L; n++) c[5*n +: 5] = 5'(n);
        run("R10 identity", 1'b0, pa, pb, c);
        check_vec("R10 identity equals A", perm_data, pa);

        // R3: lane n takes B byte (15-n)
        for (int n = 0; n < L; n++) c[5*n +: 5] = 5'(31 - n);
        run("R3 reverse B", 1'b0, pa, pb, c);

        // R4 R5: every index byte value in all lanes
        for (int k = 0; k < 256; k++) begin
            logic [VW-1:0] b;
            for (int n = 0; n < L; n++) b[8*n +: 8] = 8'(k);
            run(k < 16 ? "R4 swz splat" : "R5 swz zero", 1'b1, pa, b, '0);
        end

        // R5: upper index bits are not masked
        pb = '0;
        pb[7:0] = 8'h80; pb[15:8] = 8'h10; pb[23:16] = 8'hFF; pb[31:24] = 8'h93;
        pb[39:32] = 8'h0F;
        run("R5 unmasked high bits", 1'b1, pa, pb, '0);

        // R6: sel_ctrl has no effect in data-driven mode
        run("R6 ctrl zero", 1'b1, pa, pb, '0);
        held = perm_data;
        run("R6 ctrl ones", 1'b1, pa, pb, '1);
        check_vec("R6 same result", perm_data, held);

        // Mixed random requests in both modes
        for (int t = 0; t < 200; t++) begin
            logic [VW-1:0] ra, rb;
            logic [CW-1:0] rc;
            ra = rand_vec(); rb = rand_vec();
            rc = CW'(rand_vec());
            if (t % 3 == 0)
                for (int n = 0; n < L; n++) rb[8*n +: 4] = rb[8*n +: 4] & {4{rb[8*n+4]}};
            run((t % 2) ? "R4 R5 random" : "R2 R3 random", 1'(t % 2), ra, rb, rc);
        end

        // R9 R7: hold while idle with changing inputs
        held = perm_data;
        @(negedge clk);
        src_a = ~src_a; src_b = ~src_b; sel_ctrl = ~sel_ctrl; mode_swz = ~mode_swz;
        repeat (3) @(posedge clk);
        #1;
        check_vec("R9 hold", perm_data, held);
        check_bit("R7 valid drops", perm_valid, 1'b0);

        // R7: back-to-back requests, one result per cycle
        @(negedge clk);
        mode_swz = 1'b0; src_a = pa; src_b = '0;
        for (int n = 0; n < L; n++) sel_ctrl[5*n +: 5] = 5'(n);
        in_valid = 1'b1;
        @(posedge clk); #1;
        check_vec("R7 first of pair", perm_data, pa);
        @(negedge clk);
        src_a = ~pa;
        @(posedge clk); #1;
        in_valid = 1'b0;
        check_vec("R7 second of pair", perm_data, ~pa);
        check_bit("R7 valid second", perm_valid, 1'b1);

        // R8: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check_bit("R8 mid reset valid", perm_valid, 1'b0);
        check_vec("R8 mid reset data", perm_data, '0);
        @(negedge clk); rst = 1'b0;

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule